// File: doc/BRIEF.md
# Signed Adder-Subtractor with Overflow

This block adds or subtracts two signed operands of a parameterised width in a single combinational pass. One select input chooses between addition and subtraction. A second select input chooses the number format: two's complement or one's complement. The block returns three things: the result, the raw carry out of the top bit, and a flag that is set when the true result does not fit in the word.

Subtraction uses the same adder as addition. The subtrahend is bit-inverted before it enters the adder. In two's-complement mode the adder's carry input is set during subtraction. This supplies the extra one that completes the negation.

In one's-complement mode the carry input stays clear. Any carry out of the top bit is then fed back into the bottom bit by a second pass (end-around carry). The exported carry is always the one from the first pass, before any correction.

Top module: `addsub_core`

## Requirements
- R1: With `do_sub`=0 and `ones_mode`=0, `result` equals `opnd_x + opnd_y` modulo 2^W.
- R2: With `do_sub`=1 and `ones_mode`=0, `result` equals `opnd_x - opnd_y` modulo 2^W. It is formed as `opnd_x + ~opnd_y + 1`.
- R3: In two's-complement mode a carry out of the top bit does not change `result`. For example, with W=4, -3 + 5 gives 0010 with `carry_out`=1.
- R4: `overflow` is 1 exactly when the two adder operands share a sign and the sign of `result` differs from it. The adder operands are `opnd_x`, and `opnd_y` inverted when `do_sub`=1. The sign is bit W-1.
- R5: With `ones_mode`=1, operands are one's-complement numbers. A carry out of the top bit of the first sum is added into bit 0, so `result` decodes to the true sum whenever `overflow`=0.
- R6: `carry_out` is bit W of `opnd_x + opnd_y'`, where `opnd_y'` is `opnd_y` inverted when `do_sub`=1. The carry input is added in two's mode only. This bit is taken before any end-around correction.
- R7: In one's-complement subtraction `opnd_y` is inverted with no added one, so `result` decodes to `opnd_x - opnd_y` when `overflow`=0.
- R8: In one's-complement mode a `result` of all ones (negative zero) is never reported as overflow.
- R9: In two's-complement mode with W=4, both of the following set `overflow`: 7+6 and -7+-4. 2-7 gives 1011 with no overflow, and 7-(-7) sets `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | W | First operand (minuend for subtraction) |
| opnd_y | input | W | Second operand (subtrahend for subtraction) |
| do_sub | input | 1 | 0 = add, 1 = subtract |
| ones_mode | input | 1 | 0 = two's complement, 1 = one's complement |
| result | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of the top bit before end-around correction |
| overflow | output | 1 | Result does not fit in W signed bits |

## Verification
The checker evaluates whenever an input changes. It assumes every input carries a defined 0 or 1 and skips any evaluation where an input is unknown. The bench drives all inputs together from one task at the falling clock edge, so each set of inputs is complete and defined before any output is compared. The sweep covers every operand pair in both modes and both operations. It uses only in-range codes, so the arithmetic references in the bench are always defined.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic {
        FMT_TWOS = 1'b0,
        FMT_ONES = 1'b1
    } num_fmt_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } arith_op_e;
endpackage

// File: rtl/addsub_invert.sv
module addsub_invert #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    input  logic         inv,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] ^ inv;
    end
endmodule

// File: rtl/addsub_pg_adder.sv
module addsub_pg_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   cy;

    for (genvar i = 0; i < W; i++) begin : g_pg
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] ^ b[i];
    end

    assign cy[0] = cin;
    for (genvar i = 0; i < W; i++) begin : g_carry
        assign cy[i+1] = gen[i] | (prop[i] & cy[i]);
    end

    assign sum  = prop ^ cy[W-1:0];
    assign cout = cy[W];
endmodule

// File: rtl/addsub_ovf_unit.sv
module addsub_ovf_unit #(
    parameter int W = 4
) (
    input  logic         sign_a,
    input  logic         sign_b,
    input  logic [W-1:0] res,
    output logic         ovf
);
    logic same_sign;
    assign same_sign = ~(sign_a ^ sign_b);
    assign ovf       = same_sign & (res[W-1] ^ sign_a);
endmodule

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    input  logic         do_sub,
    input  logic         ones_mode,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow
);
    localparam logic [W-1:0] ZERO_W = '0;

    num_fmt_e     fmt;
    arith_op_e    op;
    logic [W-1:0] y_eff;
    logic [W-1:0] first_sum;
    logic         first_cy;
    logic         first_cin;
    logic         wrap_cin;
    logic [W-1:0] wrap_sum;
    logic         wrap_cy;

    assign fmt = num_fmt_e'(ones_mode);
    assign op  = arith_op_e'(do_sub);

    addsub_invert #(.W(W)) u_inv (
        .din  (opnd_y),
        .inv  (op == OP_SUB),
        .dout (y_eff)
    );

    always_comb begin
        unique case (fmt)
            FMT_TWOS: first_cin = (op == OP_SUB);
            FMT_ONES: first_cin = 1'b0;
            default:  first_cin = 1'b0;
        endcase
    end

    addsub_pg_adder #(.W(W)) u_first (
        .a    (opnd_x),
        .b    (y_eff),
        .cin  (first_cin),
        .sum  (first_sum),
        .cout (first_cy)
    );

    assign wrap_cin = (fmt == FMT_ONES) & first_cy;

    addsub_pg_adder #(.W(W)) u_wrap (
        .a    (first_sum),
        .b    (ZERO_W),
        .cin  (wrap_cin),
        .sum  (wrap_sum),
        .cout (wrap_cy)
    );

    assign result    = wrap_sum;
    assign carry_out = first_cy;

    addsub_ovf_unit #(.W(W)) u_ovf (
        .sign_a (opnd_x[W-1]),
        .sign_b (y_eff[W-1]),
        .res    (wrap_sum),
        .ovf    (overflow)
    );

    logic unused_ok;
    assign unused_ok = wrap_cy;
endmodule

// File: rtl/addsub_core_chk.sv
module addsub_core_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] opnd_x,
    input logic [W-1:0] opnd_y,
    input logic         do_sub,
    input logic         ones_mode,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         overflow
);
    logic         known;
    logic         bsign;
    logic [W:0]   ext_sum;
    logic [W-1:0] back;

    assign known   = !$isunknown({opnd_x, opnd_y, do_sub, ones_mode});
    assign bsign   = opnd_y[W-1] ^ do_sub;
    assign ext_sum = {1'b0, opnd_x} + {1'b0, opnd_y};
    assign back    = result - opnd_y;

    always_comb begin
        if (known) begin
            // R4: operands of opposite sign never overflow
            p_no_overflow_r4: assert ((opnd_x[W-1] != bsign) -> !overflow);
            // R4: a flagged overflow always has a sign flip in the result
            p_ovf_sign_r4: assert (overflow -> (result[W-1] != opnd_x[W-1]));
            // R1: two's addition can be undone by subtraction
            p_twos_add_r1: assert ((!ones_mode && !do_sub) -> (back == opnd_x));
            // R6: raw carry of a two's-complement addition
            p_carry_r6: assert ((!ones_mode && !do_sub) -> (carry_out == ext_sum[W]));
            // R8: negative zero in one's mode is not an overflow
            p_negzero_r8: assert ((ones_mode && (&result)) -> !overflow);
        end
    end
endmodule

bind addsub_core addsub_core_chk #(.W(W)) u_chk (
    .opnd_x    (opnd_x),
    .opnd_y    (opnd_y),
    .do_sub    (do_sub),
    .ones_mode (ones_mode),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/sim_addsub_core.sv
`timescale 1ns/1ps
module sim_addsub_core;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic [W-1:0] opnd_x, opnd_y;
    logic         do_sub, ones_mode;
    logic [W-1:0] result;
    logic         carry_out, overflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    addsub_core #(.W(W)) u0 (
        .opnd_x    (opnd_x),
        .opnd_y    (opnd_y),
        .do_sub    (do_sub),
        .ones_mode (ones_mode),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    function automatic int tc_val(input int u);
        return (u >= M/2) ? u - M : u;
    endfunction

    function automatic int oc_val(input int u);
        return (u >= M/2) ? -((M - 1) - u) : u;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int x, input int y, input bit s, input bit om);
        @(negedge clk);
        opnd_x    = W'(x);
        opnd_y    = W'(y);
        do_sub    = s;
        ones_mode = om;
        #1;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        drive(0, 0, 0, 0);
        chk("R1 idle result", int'(result), 0);
        chk("R4 idle overflow", int'(overflow), 0);

        // R9 worked examples
        drive(7, 6, 0, 0);       chk("R9 7+6 ovf", int'(overflow), 1);
        drive(9, 12, 0, 0);      chk("R9 -7+-4 ovf", int'(overflow), 1);
        drive(2, 7, 1, 0);       chk("R9 2-7 result", int'(result), 11);
                                 chk("R9 2-7 no ovf", int'(overflow), 0);
        drive(7, 9, 1, 0);       chk("R9 7-(-7) ovf", int'(overflow), 1);
        // R3 carry discarded
        drive(13, 5, 0, 0);      chk("R3 -3+5 result", int'(result), 2);
                                 chk("R3 -3+5 carry", int'(carry_out), 1);
        // R8 negative zero: 3 + (-3) in one's mode gives 1111
        drive(3, 12, 0, 1);      chk("R8 negzero result", int'(result), 15);
                                 chk("R8 negzero ovf", int'(overflow), 0);
        // R5 end-around: -1 + -1 = 1110+1110 -> 1101 (-2)
        drive(14, 14, 0, 1);     chk("R5 -1+-1 result", int'(result), 13);
                                 chk("R6 -1+-1 raw carry", int'(carry_out), 1);

        for (int om = 0; om < 2; om++) begin
            for (int s = 0; s < 2; s++) begin
                for (int x = 0; x < M; x++) begin
                    for (int y = 0; y < M; y++) begin
                        int ye, raw, tv, ov_e;
                        drive(x, y, bit'(s), bit'(om));
                        ye  = (s != 0) ? (M - 1 - y) : y;
                        raw = x + ye + ((om == 0 && s != 0) ? 1 : 0);
                        chk("R6 carry", int'(carry_out), raw / M);
                        if (om == 0) begin
                            tv   = (s != 0) ? tc_val(x) - tc_val(y) : tc_val(x) + tc_val(y);
                            ov_e = (tv < -(M/2) || tv > M/2 - 1) ? 1 : 0;
                            chk("R4 two's overflow", int'(overflow), ov_e);
                            chk(s != 0 ? "R2 difference" : "R1 sum",
                                int'(result), ((tv % M) + M) % M);
                        end else begin
                            tv   = (s != 0) ? oc_val(x) - oc_val(y) : oc_val(x) + oc_val(y);
                            ov_e = (tv < -(M/2 - 1) || tv > M/2 - 1) ? 1 : 0;
                            chk("R4 one's overflow", int'(overflow), ov_e);
                            if (ov_e == 0)
                                chk(s != 0 ? "R7 one's difference" : "R5 one's sum",
                                    oc_val(int'(result)), tv);
                            if (result == W'(M - 1))
                                chk("R8 negzero no ovf", int'(overflow), 0);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule